// File: doc/BRIEF.md
# Six-Output Commutation PWM Generator

This block is a timer-driven PWM source for brushless DC motor drive. A free-running counter runs against a programmable period limit (TOP). A single compare value sets the duty of one internal waveform, and that waveform is sent to all six output pins. Each pin has its own override-enable bit. When the bit is set, the pin carries the waveform. When it is clear, the pin carries a software-supplied port bit. The switch is purely combinational, so firmware can commutate motor phases in the same cycle it writes the mask.

The counter has two counting schemes, chosen by `slope_dual`. In sawtooth mode it counts 0..TOP and then wraps. In triangle mode it counts up 0..TOP and back down to 0. The counter is a two-state machine, `DIR_UP` and `DIR_DOWN`, with these transitions:
- UP→DOWN when the count equals TOP in triangle mode and TOP > 1.
- DOWN→UP when the count is 1 while going down, so the next count is 0.
- Any state→UP whenever sawtooth mode is selected, and at every overflow event.

TOP and the compare value are written into shadow registers. They move to the active registers only at the overflow event, so a period always runs with one consistent pair. A sticky overflow flag plus an enable produce an interrupt request.

Top module: `commutate_pwm`

## Requirements
- R1: In sawtooth mode (`slope_dual`=0) the count increments by one each clock. On the clock after it equals TOP it returns to 0, so the period is TOP+1 clocks.
- R2: In triangle mode (`slope_dual`=1) the count goes 0,1,..,TOP,TOP-1,..,1,0,1,.. with a period of 2·TOP clocks. TOP=0 holds the count at 0.
- R3: The overflow event is count==TOP in sawtooth mode, and count==0 while in `DIR_UP` in triangle mode. `ovf_flag` rises on the clock after the event and stays set until a clock where `ovf_clr`=1 and no new event occurs.
- R4: `irq` is high exactly while `ovf_flag` and `ovf_ie` are both high.
- R5: In sawtooth mode with 1 ≤ compare < TOP, the internal waveform is high while the count lies in [compare+1, TOP]. That is TOP−compare clocks per period.
- R6: In triangle mode with 1 ≤ compare < TOP, the waveform rises after the up-count match and falls after the down-count match. That is 2·(TOP−compare) high clocks per period.
- R7: A compare value of 0, or of TOP or more, leaves the waveform low for the whole period, with no pulse.
- R8: `out_mode` 2'b10 drives enabled pins with the waveform, and 2'b11 drives them with its inverse. 2'b00 and 2'b01 drive every pin from `port_val`.
- R9: Pin i shows the waveform only when `ovr_en[i]`=1 and `out_mode[1]`=1; otherwise it shows `port_val[i]`, in the same cycle with no register delay.
- R10: Writes through `top_we`/`cmp_we` take effect only at the next overflow event. The period in progress keeps its old TOP and compare.
- R11: After reset the count is 0, the flag and `irq` are low, the waveform is low, TOP is all ones and compare is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slope_dual | input | 1 | 0 sawtooth, 1 triangle counting |
| out_mode | input | 2 | Waveform mode: 10 normal, 11 inverted, 0x pins from port |
| top_we | input | 1 | Write strobe for the TOP shadow register |
| top_wdata | input | W | New TOP value |
| cmp_we | input | 1 | Write strobe for the compare shadow register |
| cmp_wdata | input | W | New compare value |
| ovr_en | input | NPIN | Per-pin waveform enable mask |
| port_val | input | NPIN | Software pin levels used when the waveform is not selected |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| ovf_ie | input | 1 | Overflow interrupt enable |
| count | output | W | Current counter value |
| pins | output | NPIN | The six drive outputs |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a shadow-register write landing in the middle of a period, with its effect held back until the next overflow. The bench aligns to the start of a sawtooth period by watching `count`. It writes a new compare value two clocks in, and counts high pin cycles for the rest of the period against the old duty. Random phases also switch modes and rewrite TOP and compare at arbitrary points, including values of 0 and above TOP. A cycle model checks every output after each edge.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;
endpackage

// File: rtl/cpwm_counter.sv
module cpwm_counter
    import cpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dual,
    input  logic [W-1:0] act_top,
    input  logic [W-1:0] shadow_top,
    output logic [W-1:0] cnt,
    output dir_e         dir,
    output logic         evt
);
    localparam logic [W-1:0] ONE = W'(1);

    dir_e         dir_n;
    logic [W-1:0] cnt_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir <= DIR_UP;
            cnt <= '0;
        end else begin
            dir <= dir_n;
            cnt <= cnt_n;
        end
    end

    // next state and event
    always_comb begin
        evt   = dual ? (dir == DIR_UP && cnt == '0) : (cnt == act_top);
        dir_n = dir;
        cnt_n = cnt + ONE;
        if (!dual) begin
            dir_n = DIR_UP;
            if (evt) cnt_n = '0;
        end else if (evt) begin
            dir_n = DIR_UP;
            cnt_n = (shadow_top == '0) ? '0 : ONE;
        end else begin
            unique case (dir)
                DIR_UP: begin
                    if (cnt == act_top) begin
                        cnt_n = cnt - ONE;
                        dir_n = (act_top > ONE) ? DIR_DOWN : DIR_UP;
                    end
                end
                DIR_DOWN: begin
                    cnt_n = cnt - ONE;
                    if (cnt == ONE) dir_n = DIR_UP;
                end
            endcase
        end
    end

    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual && cnt == act_top) |=> cnt == '0);
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual && cnt != act_top) |=> cnt == W'($past(cnt) + ONE));
    p_turn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dual && dir == DIR_DOWN && cnt == ONE) |=> (cnt == '0 && dir == DIR_UP));
    p_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dual && dir == DIR_DOWN) |=> cnt == W'($past(cnt) - ONE));
endmodule

// File: rtl/cpwm_wave.sv
module cpwm_wave
    import cpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dual,
    input  logic [W-1:0] cnt,
    input  dir_e         dir,
    input  logic         evt,
    input  logic [W-1:0] act_top,
    input  logic [W-1:0] act_cmp,
    output logic         wave
);
    logic hit, set_c, clr_c;

    always_comb begin
        hit   = (cnt == act_cmp);
        set_c = hit && (cnt != '0) && (cnt != act_top) && (!dual || dir == DIR_UP);
        clr_c = dual ? ((dir == DIR_DOWN && hit) || evt) : (cnt == act_top);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     wave <= 1'b0;
        else if (clr_c) wave <= 1'b0;
        else if (set_c) wave <= 1'b1;
    end

    p_flat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((act_cmp == '0 || act_cmp >= act_top) && !wave) |=> !wave);
    p_wrapclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual && cnt == act_top) |=> !wave);
endmodule

// File: rtl/cpwm_pinmux.sv
module cpwm_pinmux #(
    parameter int NPIN = 6
) (
    input  logic            wave,
    input  logic [1:0]      out_mode,
    input  logic [NPIN-1:0] ovr_en,
    input  logic [NPIN-1:0] port_val,
    output logic [NPIN-1:0] pins
);
    logic lvl;
    assign lvl = wave ^ out_mode[0];

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        assign pins[i] = (out_mode[1] && ovr_en[i]) ? lvl : port_val[i];
    end
endmodule

// File: rtl/commutate_pwm.sv
module commutate_pwm
    import cpwm_pkg::*;
#(
    parameter int W    = 8,
    parameter int NPIN = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slope_dual,
    input  logic [1:0]      out_mode,
    input  logic            top_we,
    input  logic [W-1:0]    top_wdata,
    input  logic            cmp_we,
    input  logic [W-1:0]    cmp_wdata,
    input  logic [NPIN-1:0] ovr_en,
    input  logic [NPIN-1:0] port_val,
    input  logic            ovf_clr,
    input  logic            ovf_ie,
    output logic [W-1:0]    count,
    output logic [NPIN-1:0] pins,
    output logic            ovf_flag,
    output logic            irq
);
    logic [W-1:0] top_sh, cmp_sh, top_act, cmp_act;
    dir_e         dir;
    logic         evt, wave;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_sh   <= '1;
            cmp_sh   <= '0;
            top_act  <= '1;
            cmp_act  <= '0;
            ovf_flag <= 1'b0;
        end else begin
            if (top_we) top_sh <= top_wdata;
            if (cmp_we) cmp_sh <= cmp_wdata;
            if (evt) begin
                top_act <= top_sh;
                cmp_act <= cmp_sh;
            end
            ovf_flag <= (ovf_flag && !ovf_clr) || evt;
        end
    end

    assign irq = ovf_flag & ovf_ie;

    cpwm_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .dual(slope_dual),
        .act_top(top_act), .shadow_top(top_sh),
        .cnt(count), .dir(dir), .evt(evt)
    );

    cpwm_wave #(.W(W)) u_wave (
        .clk(clk), .rst_n(rst_n), .dual(slope_dual), .cnt(count), .dir(dir),
        .evt(evt), .act_top(top_act), .act_cmp(cmp_act), .wave(wave)
    );

    cpwm_pinmux #(.NPIN(NPIN)) u_mux (
        .wave(wave), .out_mode(out_mode), .ovr_en(ovr_en),
        .port_val(port_val), .pins(pins)
    );

    p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> ovf_flag);
    p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);
    p_shadow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(cmp_act) && $stable(top_act));
    p_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_mode[1] |-> pins == port_val);
endmodule

// File: tb/commutate_pwm_tb_top.sv
module commutate_pwm_tb_top;
    localparam int CLK_P = 10;
    localparam int W = 8;
    localparam int NP = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slope_dual = 1'b0;
    logic [1:0]    out_mode = 2'b10;
    logic          top_we = 1'b0, cmp_we = 1'b0;
    logic [W-1:0]  top_wdata = '0, cmp_wdata = '0;
    logic [NP-1:0] ovr_en = '1, port_val = '0;
    logic          ovf_clr = 1'b0, ovf_ie = 1'b0;
    logic [W-1:0]  count;
    logic [NP-1:0] pins;
    logic          ovf_flag, irq;

    int tests = 0, fails = 0, hi_cnt = 0;
    bit done = 0;

    // reference model state
    logic [W-1:0] m_cnt, m_top, m_cmp, m_tsh, m_csh;
    bit m_down, m_wave, m_flag;

    always #(CLK_P/2) clk = ~clk;

    commutate_pwm #(.W(W), .NPIN(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .slope_dual(slope_dual), .out_mode(out_mode),
        .top_we(top_we), .top_wdata(top_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .ovr_en(ovr_en), .port_val(port_val), .ovf_clr(ovf_clr), .ovf_ie(ovf_ie),
        .count(count), .pins(pins), .ovf_flag(ovf_flag), .irq(irq)
    );

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [NP-1:0] exp_pins();
        logic [NP-1:0] p;
        for (int i = 0; i < NP; i++)
            p[i] = (out_mode[1] && ovr_en[i]) ? (m_wave ^ out_mode[0]) : port_val[i];
        return p;
    endfunction

    function automatic string wave_tag();
        if (!out_mode[1]) return "R8";
        if (m_cmp == 0 || m_cmp >= m_top) return "R7";
        return slope_dual ? "R6" : "R5";
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_top = '1; m_cmp = 0; m_tsh = '1; m_csh = 0;
        m_down = 0; m_wave = 0; m_flag = 0;
    endtask

    task automatic model_step();
        bit evt, hit, setw, clrw, nd;
        logic [W-1:0] nc;
        evt = slope_dual ? (!m_down && m_cnt == 0) : (m_cnt == m_top);
        hit = (m_cnt == m_cmp);
        setw = hit && m_cnt != 0 && m_cnt != m_top && (!slope_dual || !m_down);
        clrw = slope_dual ? ((m_down && hit) || evt) : (m_cnt == m_top);
        nd = m_down; nc = m_cnt + 1;
        if (!slope_dual) begin
            nd = 0; if (evt) nc = 0;
        end else if (evt) begin
            nd = 0; nc = (m_tsh == 0) ? 0 : 1;
        end else if (!m_down) begin
            if (m_cnt == m_top) begin nc = m_cnt - 1; nd = (m_top > 1); end
        end else begin
            nc = m_cnt - 1; if (m_cnt == 1) nd = 0;
        end
        if (clrw) m_wave = 0; else if (setw) m_wave = 1;
        m_flag = (m_flag && !ovf_clr) || evt;
        if (evt) begin m_top = m_tsh; m_cmp = m_csh; end
        if (top_we) m_tsh = top_wdata;
        if (cmp_we) m_csh = cmp_wdata;
        m_cnt = nc; m_down = nd;
    endtask

    // inputs are set before the call; checks at mid-low phase, then one edge
    task automatic step();
        logic [NP-1:0] ep;
        #1;
        ep = exp_pins();
        check(slope_dual ? "R2" : "R1", count, m_cnt);
        check("R3", ovf_flag, m_flag);
        check("R4", irq, m_flag && ovf_ie);
        check("R9", pins & ~(ovr_en & {NP{out_mode[1]}}), ep & ~(ovr_en & {NP{out_mode[1]}}));
        check(wave_tag(), pins & ovr_en, ep & ovr_en);
        if (pins[0]) hi_cnt++;
        model_step();
        @(posedge clk);
        @(negedge clk);
        top_we = 0; cmp_we = 0; ovf_clr = 0;
    endtask

    task automatic align0();
        int g = 0;
        #1;
        while (count != 0 && g < 600) begin step(); #1; g++; end
    endtask

    task automatic count_high(int n, string req, int exp);
        hi_cnt = 0;
        repeat (n) step();
        check(req, hi_cnt, exp);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        #1;
        check("R11", count, 0);
        check("R11", ovf_flag, 0);
        check("R11", irq, 0);
        check("R11", pins, 0);

        // R5: sawtooth TOP=9 CMP=3
        top_wdata = 9; top_we = 1; cmp_wdata = 3; cmp_we = 1;
        step();
        align0();
        count_high(10, "R5", 6);
        // R8 inverted
        out_mode = 2'b11;
        count_high(10, "R8", 4);
        out_mode = 2'b10;

        // R10: mid-period write holds until next overflow
        align0();
        step();
        cmp_wdata = 7; cmp_we = 1;
        step();
        count_high(8, "R10", 6);
        count_high(10, "R10", 2);

        // R7: compare 0 and beyond TOP
        cmp_wdata = 0; cmp_we = 1; step();
        repeat (12) step();
        align0();
        count_high(10, "R7", 0);
        cmp_wdata = 12; cmp_we = 1; step();
        repeat (12) step();
        align0();
        count_high(10, "R7", 0);

        // R6: triangle TOP=6 CMP=2
        top_wdata = 6; top_we = 1; cmp_wdata = 2; cmp_we = 1;
        step();
        repeat (12) step();
        slope_dual = 1;
        repeat (30) step();
        align0();
        count_high(12, "R6", 8);

        // R3/R4: sticky flag and clear
        ovf_ie = 1;
        step();
        check("R4", irq, 1);
        #1;
        while (count == 0 || count == 1) step();
        ovf_clr = 1; step();
        #1;
        check("R3", ovf_flag, 0);
        check("R4", irq, 0);

        // R8/R9: port pass-through and mask
        out_mode = 2'b01; port_val = 6'b101101; step();
        ovr_en = 6'b000011; out_mode = 2'b10; port_val = 6'b110000; step();

        // constrained random phase
        for (int k = 0; k < 5000; k++) begin
            if (($urandom % 150) == 0) slope_dual = $urandom;
            if (($urandom % 40) == 0) begin
                top_we = 1; top_wdata = (($urandom % 20) == 0) ? 0 : 1 + $urandom % 15;
            end
            if (($urandom % 30) == 0) begin
                cmp_we = 1; cmp_wdata = $urandom % 18;
            end
            if (($urandom % 60) == 0) out_mode = $urandom;
            ovr_en = $urandom; port_val = $urandom;
            ovf_clr = (($urandom % 8) == 0);
            ovf_ie = $urandom;
            step();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule